// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a simple internal request port and an external asynchronous static RAM with a 20-bit address and a 16-bit data bus. Each request carries a direction, an address, write data and a two-bit lane mask. The controller turns it into a timed strobe sequence on the RAM pins. That sequence has three phases: a setup phase, in which address and chip select lead the strobes; a pulse phase, in which write enable or output enable and the selected lane enables are low; and a hold phase, in which address, select and write data stay valid after the strobes rise. Each phase lasts a whole number of clock cycles, set by a parameter.

All pin strobes come straight from flip-flops, so they never glitch. A write is committed by the RAM on the rising edge of write enable at the end of the pulse. The hold phase keeps address and data steady past that edge. For a read, the bus is sampled at the clock edge that ends the last pulse cycle. Lanes that are not in the mask return zero. After every access, one cycle with all strobes released separates it from the next, so there is no read-to-write bus contention. The data bus is split into an output value, a per-lane output enable and an input value, and the tri-state buffer belongs to the pad ring.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and after its release, the chip is deselected (ramCeN=1, ramCe2=0), ramWeN=1, ramOeN=1, both lane enables are 1, no lane is driven, reqReady=1 and rspDone=0.
- R2: A request is taken on a clock edge where reqValid=1 and reqReady=1. reqReady is 1 only while no access is in progress. rspDone is 1 for exactly one cycle, the cycle that directly follows the SETUP_CYC+PULSE_CYC+HOLD_CYC access cycles.
- R3: During the access cycles ramCeN=0 and ramCe2=1, and ramAddr holds the request address. It does not change, even when reqAddr changes meanwhile.
- R4: A write holds ramWeN=1 for SETUP_CYC cycles, then ramWeN=0 for exactly PULSE_CYC cycles, then ramWeN=1 for HOLD_CYC cycles, with the chip selected throughout.
- R5: Mask bit 0 selects lane 0 (data bits 7:0, ramLaneN[0]) and mask bit 1 selects lane 1 (bits 15:8, ramLaneN[1]). A lane enable is 0 only in the pulse cycles and only if its mask bit is 1. A write with mask 00 changes no RAM contents.
- R6: ramDqOe[i] is 1 only in the pulse and hold cycles of a write whose mask bit i is 1. While it is 1, ramDqOut carries the request write data unchanged.
- R7: A read holds ramOeN=0 for exactly the PULSE_CYC pulse cycles with ramWeN=1. ramWeN and ramOeN are never both 0.
- R8: At the edge that ends the last pulse cycle of a read, rspRdata takes the ramDqIn value for each masked lane and zero for each unmasked lane. It then holds until the next read captures.
- R9: Between two accesses, even when requests are back to back, there is at least one cycle with the chip deselected and all strobes released. That cycle is the one in which rspDone=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request accepted this edge if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane select, bit i = byte lane i |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 16 | Captured read data |
| ramAddr | output | 20 | RAM address |
| ramCeN | output | 1 | Active-low chip enable |
| ramCe2 | output | 1 | Active-high chip enable |
| ramWeN | output | 1 | Active-low write enable |
| ramOeN | output | 1 | Active-low output enable |
| ramLaneN | output | 2 | Active-low byte-lane enables |
| ramDqOut | output | 16 | Data driven toward the RAM |
| ramDqOe | output | 2 | Per-lane output enable of the data pad |
| ramDqIn | input | 16 | Data received from the RAM |

## Verification
Every cycle, the assertions check the pin-level rules: write and output enables are exclusive; a lane enable is low only during a write or read strobe; the bus is driven only while selected and with output enable high; address and driven data hold steady; and write enable falls only after a selected setup cycle and rises while the chip is still selected. Only the bench scenarios can show the exact phase lengths, the mask-to-lane mapping, and that RAM contents change only in the masked lanes. The same holds for zero-filled read lanes, for ignored request changes during an access, and for the single idle cycle between back-to-back requests, all of which the bench's cycle model and its RAM model observe.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  // Registered strobes handed from control to datapath
  typedef struct packed {
    logic sel;      // chip selected
    logic wrPulse;  // write strobe low
    logic rdPulse;  // output enable low
    logic lanePulse;// lane enables low for masked lanes
    logic drive;    // write data on the bus
    logic capture;  // last read pulse cycle
  } strobe_t;

endpackage

// File: rtl/sram_lane_ctrl_fsm.sv
module sram_lane_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    load,
  output logic    rspDone,
  output strobe_t strb
);

  localparam int MAX_CYC = (SETUP_CYC > PULSE_CYC) ?
                           ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                           ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

  phase_e           phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             isWrite, isWriteNext;
  strobe_t          strbNext;
  logic             doneNext;

  assign reqReady = (phase == PH_IDLE);
  assign load     = reqReady && reqValid;

  always_comb begin
    phaseNext   = phase;
    cntNext     = cnt;
    isWriteNext = isWrite;
    doneNext    = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          phaseNext   = PH_SETUP;
          cntNext     = '0;
          isWriteNext = reqWrite;
        end
      end
      PH_SETUP: begin
        if (cnt == SETUP_LAST) begin
          phaseNext = PH_PULSE;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      PH_PULSE: begin
        if (cnt == PULSE_LAST) begin
          phaseNext = PH_HOLD;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt == HOLD_LAST) begin
          phaseNext = PH_IDLE;
          cntNext   = '0;
          doneNext  = 1'b1;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  // Strobes decoded from the next phase so the registered copy lines up
  always_comb begin
    strbNext.sel       = (phaseNext != PH_IDLE);
    strbNext.wrPulse   = (phaseNext == PH_PULSE) && isWriteNext;
    strbNext.rdPulse   = (phaseNext == PH_PULSE) && !isWriteNext;
    strbNext.lanePulse = (phaseNext == PH_PULSE);
    strbNext.drive     = isWriteNext &&
                         ((phaseNext == PH_PULSE) || (phaseNext == PH_HOLD));
    strbNext.capture   = (phaseNext == PH_PULSE) && !isWriteNext &&
                         (cntNext == PULSE_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
      strb    <= '0;
      rspDone <= 1'b0;
    end else begin
      phase   <= phaseNext;
      cnt     <= cntNext;
      isWrite <= isWriteNext;
      strb    <= strbNext;
      rspDone <= doneNext;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl_dp.sv
module sram_lane_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  load,
  input  strobe_t               strb,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqMask,
  output logic [DATA_W-1:0]     rspRdata,
  output logic [ADDR_W-1:0]     ramAddr,
  output logic                  ramCeN,
  output logic                  ramCe2,
  output logic                  ramWeN,
  output logic                  ramOeN,
  output logic [DATA_W/8-1:0]   ramLaneN,
  output logic [DATA_W-1:0]     ramDqOut,
  output logic [DATA_W/8-1:0]   ramDqOe,
  input  logic [DATA_W-1:0]     ramDqIn
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
    end
  end

  assign ramAddr  = addrQ;
  assign ramDqOut = wdataQ;
  assign ramCeN   = !strb.sel;
  assign ramCe2   = strb.sel;
  assign ramWeN   = !strb.wrPulse;
  assign ramOeN   = !strb.rdPulse;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] rdLaneQ;

    assign ramLaneN[g] = !(strb.lanePulse && maskQ[g]);
    assign ramDqOe[g]  = strb.drive && maskQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdLaneQ <= '0;
      end else if (strb.capture) begin
        rdLaneQ <= maskQ[g] ? ramDqIn[g*8 +: 8] : 8'h00;
      end
    end

    assign rspRdata[g*8 +: 8] = rdLaneQ;
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqMask,
  output logic                rspDone,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic                ramCeN,
  output logic                ramCe2,
  output logic                ramWeN,
  output logic                ramOeN,
  output logic [DATA_W/8-1:0] ramLaneN,
  output logic [DATA_W-1:0]   ramDqOut,
  output logic [DATA_W/8-1:0] ramDqOe,
  input  logic [DATA_W-1:0]   ramDqIn
);

  strobe_t strb;
  logic    load;

  sram_lane_ctrl_fsm #(
    .SETUP_CYC(SETUP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) i_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .load    (load),
    .rspDone (rspDone),
    .strb    (strb)
  );

  sram_lane_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .load    (load),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .rspRdata(rspRdata),
    .ramAddr (ramAddr),
    .ramCeN  (ramCeN),
    .ramCe2  (ramCe2),
    .ramWeN  (ramWeN),
    .ramOeN  (ramOeN),
    .ramLaneN(ramLaneN),
    .ramDqOut(ramDqOut),
    .ramDqOe (ramDqOe),
    .ramDqIn (ramDqIn)
  );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqReady,
  input logic                rspDone,
  input logic [ADDR_W-1:0]   ramAddr,
  input logic                ramCeN,
  input logic                ramWeN,
  input logic                ramOeN,
  input logic [DATA_W/8-1:0] ramLaneN,
  input logic [DATA_W-1:0]   ramDqOut,
  input logic [DATA_W/8-1:0] ramDqOe
);

  // R7
  we_oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!ramWeN && !ramOeN));

  // R5
  lane_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramLaneN != '1) |-> (!ramWeN || !ramOeN));

  // R6
  drive_only_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|ramDqOe) |-> (ramOeN && !ramCeN));

  // R6
  drive_data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|ramDqOe) && $past(|ramDqOe)) |-> $stable(ramDqOut));

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ramCeN && $past(!ramCeN)) |-> $stable(ramAddr));

  // R4
  we_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ramWeN) |-> $past(!ramCeN && ramWeN));

  // R4
  we_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> !ramCeN);

  // R9
  gap_is_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramCeN) |-> rspDone);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (ramCeN && reqReady));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .rspDone (rspDone),
  .ramAddr (ramAddr),
  .ramCeN  (ramCeN),
  .ramWeN  (ramWeN),
  .ramOeN  (ramOeN),
  .ramLaneN(ramLaneN),
  .ramDqOut(ramDqOut),
  .ramDqOe (ramDqOe)
);

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int NL = 2;
  localparam int S  = 2;
  localparam int P  = 2;
  localparam int H  = 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [NL-1:0] reqMask = '0;
  logic          rspDone;
  logic [DW-1:0] rspRdata;
  logic [AW-1:0] ramAddr;
  logic          ramCeN, ramCe2, ramWeN, ramOeN;
  logic [NL-1:0] ramLaneN, ramDqOe;
  logic [DW-1:0] ramDqOut;
  logic [DW-1:0] ramDqIn = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sram_lane_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H))
  i_sram_lane_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspDone(rspDone), .rspRdata(rspRdata), .ramAddr(ramAddr), .ramCeN(ramCeN),
    .ramCe2(ramCe2), .ramWeN(ramWeN), .ramOeN(ramOeN), .ramLaneN(ramLaneN),
    .ramDqOut(ramDqOut), .ramDqOe(ramDqOe), .ramDqIn(ramDqIn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic logic [15:0] dflt(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction

  // ---------------- behavioural RAM on the pins ----------------
  logic [15:0] ram [int];
  logic        pWeN = 1'b1;
  logic [NL-1:0] pLaneN = '1, pOe = '0;
  logic [AW-1:0] pAddr = '0;
  logic [DW-1:0] pData = '0;

  always @(negedge clk) begin
    if (rstN && pWeN == 1'b0 && ramWeN == 1'b1) begin
      logic [15:0] w;
      w = ram.exists(int'(pAddr)) ? ram[int'(pAddr)] : dflt(pAddr);
      for (int i = 0; i < NL; i++)
        if (!pLaneN[i] && pOe[i]) w[i*8 +: 8] = pData[i*8 +: 8];
      ram[int'(pAddr)] = w;
    end
    pWeN = ramWeN; pLaneN = ramLaneN; pOe = ramDqOe; pAddr = ramAddr; pData = ramDqOut;
    ramDqIn <= ram.exists(int'(ramAddr)) ? ram[int'(ramAddr)] : dflt(ramAddr);
  end

  // ---------------- cycle reference model ----------------
  int            k = 0;
  logic          mWr = 1'b0;
  logic [AW-1:0] mAddr = '0;
  logic [DW-1:0] mData = '0;
  logic [NL-1:0] mMask = '0;
  logic [DW-1:0] mRdata = '0;
  logic          mDone = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      k = 0; mDone = 1'b0; mRdata = '0;
    end else begin
      mDone = 1'b0;
      if (k == 0) begin
        if (reqValid) begin
          mWr = reqWrite; mAddr = reqAddr; mData = reqWdata; mMask = reqMask; k = 1;
        end
      end else begin
        if (k == S + P && !mWr)
          for (int i = 0; i < NL; i++)
            mRdata[i*8 +: 8] = mMask[i] ? ramDqIn[i*8 +: 8] : 8'h00;
        if (k == S + P + H) begin k = 0; mDone = 1'b1; end
        else k++;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      logic sel, pulse, hold;
      sel   = (k != 0);
      pulse = (k > S) && (k <= S + P);
      hold  = (k > S + P);
      cycles++;
      check("R2 reqReady", reqReady, k == 0);
      check("R2 rspDone", rspDone, mDone);
      check("R3 ramCeN", ramCeN, !sel);
      check("R3 ramCe2", ramCe2, sel);
      if (sel) check("R3 ramAddr", ramAddr, mAddr);
      check("R4 ramWeN", ramWeN, !(pulse && mWr));
      check("R7 ramOeN", ramOeN, !(pulse && !mWr));
      for (int i = 0; i < NL; i++) begin
        check("R5 ramLaneN", ramLaneN[i], !(pulse && mMask[i]));
        check("R6 ramDqOe", ramDqOe[i], mWr && (pulse || hold) && mMask[i]);
      end
      if (|ramDqOe) check("R6 ramDqOut", ramDqOut, mData);
      check("R8 rspRdata", rspRdata, mRdata);
      if (mDone) check("R9 idle gap", {ramCeN, ramWeN, ramOeN, ramLaneN, ramDqOe}, {3'b111, 2'b11, 2'b00});
    end
  end

  // ---------------- stimulus ----------------
  logic [15:0] gold [int];

  function automatic logic [15:0] goldRd(input logic [AW-1:0] a);
    return gold.exists(int'(a)) ? gold[int'(a)] : dflt(a);
  endfunction

  // present a request and return after the edge that accepts it
  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [NL-1:0] m);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr = ~a; reqWdata = ~d; reqMask = ~m; reqWrite = ~wr; // R3: ignored while busy
    if (wr) begin
      logic [15:0] w;
      w = goldRd(a);
      for (int i = 0; i < NL; i++) if (m[i]) w[i*8 +: 8] = d[i*8 +: 8];
      gold[int'(a)] = w;
    end
  endtask

  task automatic waitDone();
    while (!rspDone) @(negedge clk);
  endtask

  task automatic readChk(input logic [AW-1:0] a, input logic [NL-1:0] m, input string tag);
    logic [15:0] e;
    issue(1'b0, a, 16'h0, m);
    waitDone();
    e = goldRd(a);
    for (int i = 0; i < NL; i++) if (!m[i]) e[i*8 +: 8] = 8'h00;
    check(tag, rspRdata, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while reset held
    check("R1 reset pins", {ramCeN, ramCe2, ramWeN, ramOeN, ramLaneN, ramDqOe},
          {1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 2'b00});
    check("R1 reset handshake", {reqReady, rspDone}, 2'b10);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", {ramCeN, ramWeN, ramOeN, reqReady}, 4'b1111);

    // full write then read back (R4, R6, R8)
    issue(1'b1, 20'h00010, 16'hA1B2, 2'b11); waitDone();
    readChk(20'h00010, 2'b11, "R8 full read after full write");
    // low lane write only (R5)
    issue(1'b1, 20'h00010, 16'h33CC, 2'b01); waitDone();
    readChk(20'h00010, 2'b10, "R8 high lane only, low zeroed");
    readChk(20'h00010, 2'b11, "R5 low lane merged");
    // high lane write only (R5)
    issue(1'b1, 20'h00010, 16'h7700, 2'b10); waitDone();
    readChk(20'h00010, 2'b01, "R8 low lane only, high zeroed");
    readChk(20'h00010, 2'b11, "R5 high lane merged");
    // mask 00 write changes nothing (R5)
    issue(1'b1, 20'h00010, 16'hFFFF, 2'b00); waitDone();
    readChk(20'h00010, 2'b11, "R5 empty mask write ignored");
    // unwritten address, top of space (R8)
    readChk(20'hFFFFF, 2'b11, "R8 default contents");
    // back-to-back: write, write, read without waiting (R9)
    issue(1'b1, 20'hFFFFF, 16'h1234, 2'b11);
    issue(1'b1, 20'h00001, 16'hBEEF, 2'b11);
    issue(1'b0, 20'hFFFFF, 16'h0, 2'b11);
    waitDone();
    check("R9 back-to-back read", rspRdata, 16'h1234);
    readChk(20'h00001, 2'b11, "R6 second back-to-back write");
    // read with no lanes gives zero (R8)
    readChk(20'h00001, 2'b00, "R8 empty mask read");
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule